// File: doc/BRIEF.md
# Serial Flash Command Front-End Emulator

This block stands in for the command front end of a serial flash device on the device side of an SPI link (mode 0: the host drives SI and samples SO on SCK rising edges, and the device changes SO after SCK falling edges). It oversamples SCK, the active-low chip select and SI with the local clock. It decodes four command opcodes:

- A security-register read.
- Two main-page-to-buffer transfer commands, one for each buffer.
- A status read.

Read data is returned on SO with its output enable. The enable is low whenever no read is driving the pin. The main array and the buffers are not modelled. For a transfer command, the block captures the buffer choice and the 13-bit page number. It arms the transfer and starts a busy period of `BUSY_CYCLES` clock cycles on the chip-select rising edge that closes a complete command. The busy state is visible on a ready output and in the status byte. The captured page number and buffer are presented on output ports.

The controller is a single state machine with these states:

- ST_IDLE: chip select high.
- ST_OPCODE: first 8 bits.
- ST_DUMMY: dummy bytes of the security read.
- ST_SECOUT: security bytes going out.
- ST_FILL: filler after the last security byte.
- ST_STATUS: status byte repeating.
- ST_ADDR: 24 address bits of a transfer.
- ST_ARMED: complete transfer command waiting for chip select to rise.
- ST_IGNORE: unknown opcode.

Transitions:

- ST_IDLE→ST_OPCODE on chip-select assertion.
- ST_OPCODE→ST_DUMMY, ST_ADDR, ST_STATUS or ST_IGNORE on the eighth rising edge, according to the opcode.
- ST_DUMMY→ST_SECOUT on the last dummy bit.
- ST_SECOUT→ST_FILL when the last security byte is loaded.
- ST_ADDR→ST_ARMED on the 24th address bit.
- Any state→ST_IDLE on chip-select deassertion. Leaving ST_ARMED this way issues the transfer start.

Top module: `flash_cmd_emu`

## Requirements
- R1: After reset, so_en is 0, rdy is 1, page_addr is 0 and page_buf is 0.
- R2: Opcode 0x77 followed by three dummy bytes returns the security register, MSB first, one byte per 8 SCK cycles. Byte k has the value (0xA5 + k·0x1D) mod 256, for k = 0 to SEC_BYTES−1 (16 by default).
- R3: After the last security byte, every further byte read in the same frame is the filler value 0xFF.
- R4: so_en is 0 during the opcode, dummy and address phases, is 1 while read data is driven, and returns to 0 within a few clock cycles of cs_n rising.
- R5: Opcode 0x53 selects buffer 1 (page_buf = 0) and opcode 0x55 selects buffer 2 (page_buf = 1). With bin_mode = 0, page_addr takes bits 22:10 of the 24-bit address sent MSB first.
- R6: With bin_mode = 1, page_addr takes bits 21:9 of the 24-bit address.
- R7: rdy stays 1 until cs_n rises after a complete 32-bit transfer command. It then goes to 0 for BUSY_CYCLES clock cycles and returns to 1.
- R8: A transfer command cut short by cs_n rising before all 32 bits leaves rdy at 1 and page_addr and page_buf unchanged.
- R9: Opcode 0xD7 returns the status byte repeatedly while cs_n stays low. Bit 7 is 1 when ready and 0 when busy, and bits 6:0 are 0x34. The status byte is therefore 0xB4 when idle and 0x34 when busy.
- R10: Any other opcode leaves so_en at 0 for the rest of the frame, starts no busy period and leaves page_addr and page_buf unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, at least 16 times the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select from the host |
| si | input | 1 | Serial data from the host |
| bin_mode | input | 1 | Page address layout: 0 standard, 1 binary |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for SO; 0 means high impedance |
| rdy | output | 1 | 1 when no transfer is busy |
| page_addr | output | 13 | Page number of the last armed transfer |
| page_buf | output | 1 | Buffer of the last armed transfer (0 = buffer 1) |

## Verification
Each SO bit is updated three clock cycles after an SCK falling edge: two synchroniser stages plus the output register. The bench drives SCK with 8-cycle half periods and samples SO and so_en at the next rising edge, eight cycles after the fall. On a closing cs_n rise, page_addr and page_buf are latched three cycles later and rdy falls one cycle after that. The bench checks them eight cycles after the rise. It brackets the end of the busy period by sampling rdy 20 cycles before and 10 cycles after BUSY_CYCLES has elapsed from the rise. After that rise, so_en is checked six cycles later.

// File: rtl/flash_emu_pkg.sv
`timescale 1ns/1ps
package flash_emu_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DUMMY,
        ST_SECOUT,
        ST_FILL,
        ST_STATUS,
        ST_ADDR,
        ST_ARMED,
        ST_IGNORE
    } emu_state_t;

    localparam logic [7:0] OP_SEC_READ = 8'h77;
    localparam logic [7:0] OP_XFER_B1  = 8'h53;
    localparam logic [7:0] OP_XFER_B2  = 8'h55;
    localparam logic [7:0] OP_STATUS   = 8'hD7;

endpackage

// File: rtl/flash_emu_sync.sv
`timescale 1ns/1ps
module flash_emu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_rise,
    output logic si_s
);

    logic [STAGES:0] sck_p;
    logic [STAGES:0] csn_p;
    logic [STAGES-1:0] si_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            csn_p <= '1;
            si_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sck};
            csn_p <= {csn_p[STAGES-1:0], cs_n};
            si_p  <= {si_p[STAGES-2:0], si};
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_act   = ~csn_p[STAGES-1];
    assign cs_rise  = csn_p[STAGES-1] & ~csn_p[STAGES];
    assign si_s     = si_p[STAGES-1];

endmodule

// File: rtl/flash_emu_secreg.sv
`timescale 1ns/1ps
module flash_emu_secreg #(
    parameter int         SEC_BYTES = 16,
    parameter int         IDX_W     = 4,
    parameter logic [7:0] SEC_SEED  = 8'hA5,
    parameter logic [7:0] SEC_STEP  = 8'h1D
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       rdata
);

    logic [7:0] regs [SEC_BYTES];

    for (genvar g = 0; g < SEC_BYTES; g++) begin : g_byte
        localparam logic [7:0] K = 8'(g);
        assign regs[g] = SEC_SEED + K * SEC_STEP;
    end

    always_comb begin
        if (32'(idx) < SEC_BYTES) rdata = regs[idx];
        else                      rdata = 8'h00;
    end

endmodule

// File: rtl/flash_emu_timer.sv
`timescale 1ns/1ps
module flash_emu_timer #(
    parameter int BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= CW'(BUSY_CYCLES);
        else if (remain != '0)   remain <= remain - CW'(1);
    end

    assign busy = (remain != '0);

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R7
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(remain) <= BUSY_CYCLES);

endmodule

// File: rtl/flash_emu_fsm.sv
`timescale 1ns/1ps
module flash_emu_fsm
    import flash_emu_pkg::*;
#(
    parameter int         SEC_BYTES   = 16,
    parameter int         IDX_W       = 4,
    parameter int         DUMMY_BYTES = 3,
    parameter int         ADDR_BITS   = 24,
    parameter int         PAGE_W      = 13,
    parameter logic [7:0] FILL_BYTE   = 8'hFF,
    parameter logic [6:0] STAT_LOW    = 7'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_act,
    input  logic              cs_rise,
    input  logic              si_s,
    input  logic              bin_mode,
    input  logic              busy,
    input  logic [7:0]        sec_rdata,
    output logic [IDX_W-1:0]  sec_idx,
    output logic              so,
    output logic              so_en,
    output logic              start,
    output logic [PAGE_W-1:0] page_addr,
    output logic              page_buf
);

    localparam int DUMMY_BITS = DUMMY_BYTES * 8;
    localparam int RX_MAX     = (DUMMY_BITS > ADDR_BITS) ? DUMMY_BITS : ADDR_BITS;
    localparam int CNT_W      = $clog2(RX_MAX + 1);
    localparam int STD_LSB    = ADDR_BITS - 1 - PAGE_W;
    localparam int BIN_LSB    = ADDR_BITS - 2 - PAGE_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEC_BYTES - 1);

    emu_state_t state, nxt;

    logic [CNT_W-1:0]     bit_cnt;
    logic [ADDR_BITS-2:0] rx_sr;
    logic [ADDR_BITS-1:0] rx_word;
    logic [7:0]           rx_op;
    logic [2:0]           tx_cnt;
    logic [7:0]           tx_sr;
    logic [7:0]           tx_byte;
    logic                 so_r;
    logic                 out_state;
    logic                 tx_load;
    logic [IDX_W-1:0]     byte_idx;
    logic                 pend_buf;
    logic [PAGE_W-1:0]    pend_page;
    logic [PAGE_W-1:0]    page_q;
    logic                 buf_q;
    logic                 start_q;

    assign rx_word   = {rx_sr, si_s};
    assign rx_op     = rx_word[7:0];
    assign out_state = (state == ST_SECOUT) || (state == ST_FILL) || (state == ST_STATUS);
    assign tx_load   = out_state && sck_fall && (tx_cnt == 3'd0);
    assign sec_idx   = byte_idx;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cs_act) nxt = ST_OPCODE;
            ST_OPCODE: begin
                if (sck_rise && bit_cnt == CNT_W'(7)) begin
                    case (rx_op)
                        OP_SEC_READ: nxt = ST_DUMMY;
                        OP_XFER_B1:  nxt = ST_ADDR;
                        OP_XFER_B2:  nxt = ST_ADDR;
                        OP_STATUS:   nxt = ST_STATUS;
                        default:     nxt = ST_IGNORE;
                    endcase
                end
            end
            ST_DUMMY:  if (sck_rise && bit_cnt == CNT_W'(DUMMY_BITS - 1)) nxt = ST_SECOUT;
            ST_SECOUT: if (tx_load && byte_idx == LAST_IDX) nxt = ST_FILL;
            ST_ADDR:   if (sck_rise && bit_cnt == CNT_W'(ADDR_BITS - 1)) nxt = ST_ARMED;
            ST_FILL, ST_STATUS, ST_ARMED, ST_IGNORE: nxt = state;
            default:   nxt = ST_IDLE;
        endcase
        if (!cs_act) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // receive datapath and transfer capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            pend_buf  <= 1'b0;
            pend_page <= '0;
            page_q    <= '0;
            buf_q     <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            if (state != nxt)  bit_cnt <= '0;
            else if (sck_rise) bit_cnt <= bit_cnt + CNT_W'(1);
            if (sck_rise) rx_sr <= rx_word[ADDR_BITS-2:0];
            if (state == ST_OPCODE && nxt == ST_ADDR)
                pend_buf <= (rx_op == OP_XFER_B2);
            if (state == ST_ADDR && nxt == ST_ARMED)
                pend_page <= bin_mode ? rx_word[BIN_LSB +: PAGE_W]
                                      : rx_word[STD_LSB +: PAGE_W];
            start_q <= cs_rise && (state == ST_ARMED);
            if (cs_rise && state == ST_ARMED) begin
                page_q <= pend_page;
                buf_q  <= pend_buf;
            end
        end
    end

    // transmit byte source
    always_comb begin
        unique case (state)
            ST_SECOUT: tx_byte = sec_rdata;
            ST_STATUS: tx_byte = {~busy, STAT_LOW};
            default:   tx_byte = FILL_BYTE;
        endcase
    end

    // transmit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt   <= '0;
            tx_sr    <= '0;
            so_r     <= 1'b0;
            byte_idx <= '0;
        end else if (state == ST_IDLE) begin
            tx_cnt   <= '0;
            tx_sr    <= '0;
            so_r     <= 1'b0;
            byte_idx <= '0;
        end else if (tx_load) begin
            so_r   <= tx_byte[7];
            tx_sr  <= {tx_byte[6:0], 1'b0};
            tx_cnt <= 3'd7;
            if (state == ST_SECOUT && byte_idx != LAST_IDX)
                byte_idx <= byte_idx + IDX_W'(1);
        end else if (out_state && sck_fall) begin
            so_r   <= tx_sr[7];
            tx_sr  <= {tx_sr[6:0], 1'b0};
            tx_cnt <= tx_cnt - 3'd1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_SECOUT, ST_FILL, ST_STATUS: so_en = 1'b1;
            default:                       so_en = 1'b0;
        endcase
    end

    assign so        = so_r;
    assign start     = start_q;
    assign page_addr = page_q;
    assign page_buf  = buf_q;

    // R4
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_en);

    // R8
    arm_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> ($past(state) == ST_ARMED));

    // R10
    ignore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> (state == ST_IGNORE || state == ST_IDLE));

    // R3
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_idx <= LAST_IDX);

endmodule

// File: rtl/flash_cmd_emu.sv
`timescale 1ns/1ps
module flash_cmd_emu #(
    parameter int         SEC_BYTES   = 16,
    parameter logic [7:0] SEC_SEED    = 8'hA5,
    parameter logic [7:0] SEC_STEP    = 8'h1D,
    parameter logic [7:0] FILL_BYTE   = 8'hFF,
    parameter logic [6:0] STAT_LOW    = 7'h34,
    parameter int         BUSY_CYCLES = 400,
    parameter int         DUMMY_BYTES = 3,
    parameter int         ADDR_BITS   = 24,
    parameter int         PAGE_W      = 13,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              bin_mode,
    output logic              so,
    output logic              so_en,
    output logic              rdy,
    output logic [PAGE_W-1:0] page_addr,
    output logic              page_buf
);

    localparam int IDX_W = (SEC_BYTES > 1) ? $clog2(SEC_BYTES) : 1;

    logic             sck_rise, sck_fall, cs_act, cs_rise, si_s;
    logic             busy, start;
    logic [IDX_W-1:0] sec_idx;
    logic [7:0]       sec_rdata;

    flash_emu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .si       (si),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_rise  (cs_rise),
        .si_s     (si_s)
    );

    flash_emu_secreg #(
        .SEC_BYTES (SEC_BYTES),
        .IDX_W     (IDX_W),
        .SEC_SEED  (SEC_SEED),
        .SEC_STEP  (SEC_STEP)
    ) u_secreg (
        .idx   (sec_idx),
        .rdata (sec_rdata)
    );

    flash_emu_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    flash_emu_fsm #(
        .SEC_BYTES   (SEC_BYTES),
        .IDX_W       (IDX_W),
        .DUMMY_BYTES (DUMMY_BYTES),
        .ADDR_BITS   (ADDR_BITS),
        .PAGE_W      (PAGE_W),
        .FILL_BYTE   (FILL_BYTE),
        .STAT_LOW    (STAT_LOW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_act    (cs_act),
        .cs_rise   (cs_rise),
        .si_s      (si_s),
        .bin_mode  (bin_mode),
        .busy      (busy),
        .sec_rdata (sec_rdata),
        .sec_idx   (sec_idx),
        .so        (so),
        .so_en     (so_en),
        .start     (start),
        .page_addr (page_addr),
        .page_buf  (page_buf)
    );

    assign rdy = ~busy;

endmodule

// File: tb/test_flash_cmd_emu.sv
`timescale 1ns/1ps
module test_flash_cmd_emu;

    localparam int HALF = 8;
    localparam int BUSY = 1500;
    localparam int SECN = 16;

    logic        clk = 1'b0;
    logic        rst_n, sck, cs_n, si, bin_mode;
    logic        so, so_en, rdy, page_buf;
    logic [12:0] page_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_cmd_emu #(.BUSY_CYCLES(BUSY)) i_flash_cmd_emu (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .bin_mode(bin_mode), .so(so), .so_en(so_en), .rdy(rdy),
        .page_addr(page_addr), .page_buf(page_buf)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] sec_val(input int k);
        return 8'(8'hA5 + k * 8'h1D);
    endfunction

    // one SPI byte: drive mo, sample so at each rising edge, check so_en
    task automatic xbyte(input logic [7:0] mo, input bit en_exp, input string tag,
                         output logic [7:0] mi);
        int bad = 0;
        for (int b = 7; b >= 0; b--) begin
            si = mo[b];
            hold(HALF);
            sck = 1'b1;
            mi[b] = so;
            if (so_en !== en_exp) bad++;
            hold(HALF);
            sck = 1'b0;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic status_read(input int n, input logic [7:0] ev, input string tag);
        logic [7:0] d;
        cs_n = 1'b0; hold(HALF);
        xbyte(8'hD7, 1'b0, "R4 so_en low in status opcode", d);
        for (int i = 0; i < n; i++) begin
            expect_byte(ev, tag);
            xbyte(8'h00, 1'b1, "R9 so_en high in status data", d);
            got_q.push_back(d);
        end
        hold(HALF); cs_n = 1'b1; hold(2 * HALF);
    endtask

    // transfer command; nb address bytes sent; returns cycle of cs_n rise
    task automatic send_xfer(input logic [7:0] op, input logic [23:0] addr,
                             input int nb, output int t0);
        logic [7:0] d;
        cs_n = 1'b0; hold(HALF);
        xbyte(op, 1'b0, "R4 so_en low in transfer opcode", d);
        for (int i = 0; i < nb; i++)
            xbyte(addr[23 - 8*i -: 8], 1'b0, "R4 so_en low in address", d);
        hold(HALF);
        check(rdy == 1'b1, "R7 ready before CS rise", rdy, 1);
        cs_n = 1'b1;
        t0 = cyc;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin : monitor
        logic [7:0] g, e;
        string t;
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(g == e, t, g, e);
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : driver
        logic [7:0]  d;
        logic [12:0] prev_page;
        logic [23:0] a;
        int t0;
        sck = 1'b0; cs_n = 1'b1; si = 1'b0; bin_mode = 1'b0; rst_n = 1'b0;
        hold(5);
        rst_n = 1'b1;
        hold(5);
        check(so_en == 1'b0, "R1 reset so_en", so_en, 0);
        check(rdy == 1'b1, "R1 reset rdy", rdy, 1);
        check(page_addr == 13'h0, "R1 reset page_addr", page_addr, 0);
        check(page_buf == 1'b0, "R1 reset page_buf", page_buf, 0);

        // security read with filler afterwards
        cs_n = 1'b0; hold(HALF);
        xbyte(8'h77, 1'b0, "R4 so_en low in opcode", d);
        for (int i = 0; i < 3; i++) xbyte(8'h5A, 1'b0, "R4 so_en low in dummy", d);
        for (int k = 0; k < SECN + 3; k++) begin
            if (k < SECN) expect_byte(sec_val(k), "R2 security byte");
            else          expect_byte(8'hFF, "R3 filler byte");
            xbyte(8'h00, 1'b1, "R4 so_en high in read data", d);
            got_q.push_back(d);
        end
        hold(HALF); cs_n = 1'b1;
        hold(6);
        check(so_en == 1'b0, "R4 high impedance after CS rise", so_en, 0);
        hold(2 * HALF);

        // idle status, repeated
        status_read(3, 8'hB4, "R9 idle status");

        // buffer 1, standard layout
        a = 24'h5A5C3F;
        send_xfer(8'h53, a, 3, t0);
        hold(8);
        check(rdy == 1'b0, "R7 busy after CS rise", rdy, 0);
        check(page_addr == 13'((a >> 10) & 24'h1FFF), "R5 standard page", page_addr, 13'((a >> 10) & 24'h1FFF));
        check(page_buf == 1'b0, "R5 buffer 1", page_buf, 0);
        status_read(2, 8'h34, "R9 busy status");
        while (cyc < t0 + BUSY - 20) @(negedge clk);
        check(rdy == 1'b0, "R7 still busy near end", rdy, 0);
        while (cyc < t0 + BUSY + 10) @(negedge clk);
        check(rdy == 1'b1, "R7 ready after busy period", rdy, 1);
        status_read(1, 8'hB4, "R9 status after busy");

        // buffer 2, binary layout
        bin_mode = 1'b1;
        a = 24'hC3A1F0;
        send_xfer(8'h55, a, 3, t0);
        hold(8);
        check(page_addr == 13'((a >> 9) & 24'h1FFF), "R6 binary page", page_addr, 13'((a >> 9) & 24'h1FFF));
        check(page_buf == 1'b1, "R5 buffer 2", page_buf, 1);
        check(rdy == 1'b0, "R7 busy after binary transfer", rdy, 0);
        while (cyc < t0 + BUSY + 10) @(negedge clk);
        prev_page = page_addr;

        // abandoned transfer: only two address bytes
        bin_mode = 1'b0;
        send_xfer(8'h53, 24'h123456, 2, t0);
        hold(10);
        check(rdy == 1'b1, "R8 no busy on short command", rdy, 1);
        check(page_addr == prev_page, "R8 page unchanged", page_addr, prev_page);
        check(page_buf == 1'b1, "R8 buffer unchanged", page_buf, 1);
        hold(2 * HALF);

        // unknown opcode
        cs_n = 1'b0; hold(HALF);
        xbyte(8'h3C, 1'b0, "R10 so_en low on unknown opcode", d);
        xbyte(8'h53, 1'b0, "R10 so_en low in ignored frame", d);
        xbyte(8'h77, 1'b0, "R10 so_en low in ignored frame", d);
        xbyte(8'hD7, 1'b0, "R10 so_en low in ignored frame", d);
        hold(HALF); cs_n = 1'b1;
        hold(10);
        check(rdy == 1'b1, "R10 no busy after unknown opcode", rdy, 1);
        check(page_addr == prev_page, "R10 page unchanged", page_addr, prev_page);
        hold(2 * HALF);
        status_read(1, 8'hB4, "R10 status stays ready");

        hold(20);
        check(exp_q.size() == 0 && got_q.size() == 0, "scoreboard drained",
              exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule